// File: doc/BRIEF.md
# Set/Clear GPIO Port Controller

A general-purpose I/O port of `NPINS` pins (32 by default) reached through a small word-addressed register bus. Software never writes the output latch as a whole. One register raises the pins whose mask bit is 1, and a second register lowers them. A write to either of these registers also turns the selected pins into outputs. A third register returns selected pins to high-impedance input mode. Pins whose mask bit is 0 are left alone in every case.

Pin levels come into the block through a two-stage synchronizer and are read back through a pin-state register. After reset, input sampling is off and the pin-state register reads as zero. Sampling turns on with the first write of any value to the input-enable register and then stays on until the next reset. Writes take effect on the clock edge that samples the write strobe. Read data appears one cycle after the read strobe.

Register map (word index on `bus_addr`): 0 raise-mask, 1 lower-mask, 2 float-mask, 3 pin-state (read only), 4 input-enable (write only). Indices 5 to 7 are unused.

Top module: `gpio_setclr_port`

## Requirements
- R1: While reset is active and after it is released, `pad_oe`, `pad_out` and `bus_rdata` are all zero: every pin is an input and every output latch is 0.
- R2: A write to index 0 sets `pad_out[i]` to 1 for each bit i that is 1 in `bus_wdata`. The other bits of `pad_out` keep their values.
- R3: A write to index 1 sets `pad_out[i]` to 0 for each bit i that is 1 in `bus_wdata`. The other bits of `pad_out` keep their values.
- R4: A write to index 0 or index 1 sets `pad_oe[i]` to 1 for each mask bit that is 1. The direction of the other pins does not change.
- R5: A write to index 2 clears `pad_oe[i]` for each mask bit that is 1. `pad_out` is not changed, and the other pins keep their direction.
- R6: A read of index 3 returns the value that `pad_in` held two clock edges before the read strobe is sampled, on `bus_rdata` in the cycle after the strobe. A pad change is therefore returned only by a read whose strobe comes at least two edges after the change. A read strobed one edge after the change still returns the old level.
- R7: Before the input-enable register has been written, a read of index 3 returns zero whatever the pad levels are.
- R8: Any write to index 4 enables input sampling, including a write of zero. Sampling stays enabled after later writes to index 4.
- R9: A write to index 3 or to an unused index changes neither `pad_out` nor `pad_oe`. A read of any index other than 3 returns zero, and `bus_rdata` is zero in every cycle that does not follow a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | AW | Register word index |
| bus_wdata | input | NPINS | Write data / pin mask |
| bus_rdata | output | NPINS | Read data, valid one cycle after the read strobe |
| pad_in | input | NPINS | Pin levels from the pads (asynchronous) |
| pad_out | output | NPINS | Output latch value per pin |
| pad_oe | output | NPINS | Output enable per pin (1 = driving) |

## Verification
The hardest case to reach from the ports is the edge of the synchronizer window in R6. Here a read issued one edge after a pad change must still return the old level, and a read issued one edge later must return the new one. The bench changes the pads on a falling edge and puts the read strobe exactly one edge later, then issues a second read straight after the first. The pad model loops driven pins back onto `pad_in`, so the expected pin state is a mix of latch values and external levels set by the current direction mask. The inputs are also driven for several cycles before the enable write, so that R7 is checked against data that is really present on the pads.

// File: rtl/gpio_setclr_port.sv
module gpio_setclr_port #(
  parameter int NPINS = 32,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] bus_rdata,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe
);

  localparam logic [AW-1:0] A_RAISE = AW'(0);
  localparam logic [AW-1:0] A_LOWER = AW'(1);
  localparam logic [AW-1:0] A_FLOAT = AW'(2);
  localparam logic [AW-1:0] A_STATE = AW'(3);
  localparam logic [AW-1:0] A_INEN  = AW'(4);

  logic [NPINS-1:0] lat_q, dir_q, sy1_q, sy2_q, state;
  logic             live_q;

  wire wr_raise = bus_wr && (bus_addr == A_RAISE);
  wire wr_lower = bus_wr && (bus_addr == A_LOWER);
  wire wr_float = bus_wr && (bus_addr == A_FLOAT);
  wire wr_inen  = bus_wr && (bus_addr == A_INEN);
  wire rd_state = bus_rd && (bus_addr == A_STATE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      dir_q <= '0;
    end else begin
      if (wr_raise) lat_q <= lat_q | bus_wdata;
      if (wr_lower) lat_q <= lat_q & ~bus_wdata;
      if (wr_raise || wr_lower) dir_q <= dir_q | bus_wdata;
      if (wr_float) dir_q <= dir_q & ~bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      sy1_q  <= '0;
      sy2_q  <= '0;
    end else begin
      if (wr_inen) live_q <= 1'b1;
      sy1_q <= pad_in;
      sy2_q <= sy1_q;
    end
  end

  assign state = live_q ? sy2_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_state ? state : '0;
  end

  assign pad_out = lat_q;
  assign pad_oe  = dir_q;

  // R1
  rst_quiet_chk: assert property (@(posedge clk) !rst_n |-> (pad_oe == '0 && pad_out == '0 && bus_rdata == '0));

  // R2
  raise_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_raise |=> ((pad_out & $past(bus_wdata)) == $past(bus_wdata)) &&
                 ((pad_out & ~$past(bus_wdata)) == ($past(pad_out) & ~$past(bus_wdata))));

  // R3
  lower_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lower |=> ((pad_out & $past(bus_wdata)) == '0) &&
                 ((pad_out & ~$past(bus_wdata)) == ($past(pad_out) & ~$past(bus_wdata))));

  // R4
  drive_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_raise || wr_lower) |=> ((pad_oe & $past(bus_wdata)) == $past(bus_wdata)) &&
                               ((pad_oe & ~$past(bus_wdata)) == ($past(pad_oe) & ~$past(bus_wdata))));

  // R5
  float_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_float |=> ((pad_oe & $past(bus_wdata)) == '0) && $stable(pad_out));

  // R7
  dead_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !live_q |=> (bus_rdata == '0));

  // R8
  live_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |=> live_q);

  // R9
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_state |=> (bus_rdata == '0));

endmodule

// File: tb/tb_gpio_setclr_port.sv
`timescale 1ns/1ps
module tb_gpio_setclr_port;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]   bus_addr = '0;
  logic [N-1:0] bus_wdata = '0;
  logic [N-1:0] bus_rdata, pad_out, pad_oe, pad_in;
  logic [N-1:0] ext = '0;
  logic [N-1:0] m_out = '0, m_oe = '0;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

  gpio_setclr_port dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a == 3'd0) begin m_out |= d;  m_oe |= d; end
    if (a == 3'd1) begin m_out &= ~d; m_oe |= d; end
    if (a == 3'd2) m_oe &= ~d;
  endtask

  task automatic rd(input logic [2:0] a, output logic [N-1:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  function automatic logic [N-1:0] pins_exp();
    return (m_oe & m_out) | (~m_oe & ext);
  endfunction

  task automatic t_reset();
    check("R1 oe", pad_oe, '0);
    check("R1 out", pad_out, '0);
    check("R1 rdata", bus_rdata, '0);
  endtask

  task automatic t_dead_input();
    logic [N-1:0] v;
    ext = 32'hA5A5_0F0F;
    repeat (4) @(negedge clk);
    rd(3'd3, v);
    check("R7 state before enable", v, '0);
  endtask

  task automatic t_enable();
    logic [N-1:0] v;
    wr(3'd4, '0);
    rd(3'd3, v);
    check("R8 enabled by zero write", v, pins_exp());
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd3, v);
    check("R8 stays enabled", v, pins_exp());
  endtask

  task automatic t_raise();
    wr(3'd0, 32'h0000_00F0);
    check("R2 raise", pad_out, m_out);
    check("R4 raise dir", pad_oe, m_oe);
    wr(3'd0, 32'h0000_0F00);
    check("R2 others kept", pad_out, 32'h0000_0FF0);
    check("R4 others kept", pad_oe, 32'h0000_0FF0);
  endtask

  task automatic t_lower();
    wr(3'd1, 32'h0000_0030);
    check("R3 lower", pad_out, 32'h0000_0FC0);
    wr(3'd1, 32'h8000_0000);
    check("R3 lower unaffected", pad_out, 32'h0000_0FC0);
    check("R4 lower makes output", pad_oe, 32'h8000_0FF0);
  endtask

  task automatic t_loopback();
    logic [N-1:0] v;
    repeat (3) @(negedge clk);
    rd(3'd3, v);
    check("R6 mixed pin state", v, pins_exp());
  endtask

  task automatic t_float();
    logic [N-1:0] v;
    wr(3'd2, 32'h8000_00C0);
    check("R5 float dir", pad_oe, 32'h0000_0F30);
    check("R5 latch kept", pad_out, 32'h0000_0FC0);
    repeat (3) @(negedge clk);
    rd(3'd3, v);
    check("R5 floated pins read pads", v, pins_exp());
  endtask

  task automatic t_sync_edge();
    logic [N-1:0] old_exp, v;
    old_exp = pins_exp();
    @(negedge clk);
    ext = ~ext;
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 3'd3;
    @(negedge clk);
    v = bus_rdata;
    check("R6 one edge old", v, old_exp);
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
    check("R6 two edges new", v, pins_exp());
  endtask

  task automatic t_ignored();
    logic [N-1:0] v;
    wr(3'd3, 32'hFFFF_FFFF);
    wr(3'd5, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    check("R9 out untouched", pad_out, m_out);
    check("R9 oe untouched", pad_oe, m_oe);
    rd(3'd0, v);
    check("R9 read idx0 zero", v, '0);
    rd(3'd6, v);
    check("R9 read idx6 zero", v, '0);
    @(negedge clk);
    check("R9 idle rdata zero", bus_rdata, '0);
  endtask

  initial begin
    #1;
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_dead_input();
    t_enable();
    t_raise();
    t_lower();
    t_loopback();
    t_float();
    t_sync_edge();
    t_ignored();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule